// File: doc/BRIEF.md
# Slot-Addressed Event Readout Slave

This block is the bus slave of a data-acquisition readout board. It owns a 64 KB address window. The window's base comes from the board's 6-bit slot number, so no base register has to be configured. The window is cut into eight 8 KB regions, selected by address bits 15 to 13:

| Code | Region |
|---|---|
| 0 | identity |
| 1 | control and status |
| 2 | test memory |
| 3 | serial command |
| 4 | serial readback |
| 5 | event buffer |
| 6, 7 | reserved |

A producer port on the other side loads complete, fixed-size events into the event buffer. The producer formats each event itself: header words, tracker header (empty in scope and software-trigger modes), payload and trailer.

A host reads events with a poll handshake:
1. Poll the ready flag.
2. Read the length.
3. Fetch the words from the event buffer region with single or block cycles.
4. Write the release bit so that the next event can load.

While an event waits for the host, the producer is held off.

Each host beat is one strobe cycle. The first beat of a bus cycle carries a start flag and the address. Later beats of a block transfer carry no address: the slave steps the word address itself. A small state machine tracks this with two states:
- `CYC_IDLE`: no block transfer is open.
- `CYC_BURST`: a block transfer is open and the next continuation beat is accepted.

The transitions are:
- `open_burst`: an accepted start beat with the block flag set moves `CYC_IDLE` to `CYC_BURST`.
- `continue_burst`: a continuation beat that stays inside the region keeps `CYC_BURST`.
- `restart_burst`: a new start beat with the block flag set keeps `CYC_BURST`.
- `end_burst`: a continuation beat that would leave the region, or a start beat without the block flag or with a rejected block, returns to `CYC_IDLE`.

Top module: `geo_readout_slave`

## Requirements
- R1: The slave answers a beat only when both `bus_a32` and `bus_d32` are high. For any other width combination it raises neither `bus_ack` nor `bus_err`.
- R2: A start beat is answered only under all of these conditions:
  - address bits 21:16 equal `slot_id`;
  - address bits 31:22 are zero;
  - address bits 1:0 are zero.
  Slot 17 therefore answers at 0x0011_0000 to 0x0011_FFFC.
- R3: An answered beat gets exactly one of `bus_ack` or `bus_err`, for one cycle, in the cycle after its strobe. A response never appears without a strobe in the previous cycle.
- R4: Address bits 15:13 select the region as listed above. In the identity region, word 0 reads `ID_CODE` and word 1 reads the slot number in bits 5:0.
- R5: A block-flagged start beat aimed at the control region gets `bus_err` and changes no state.
- R6: Each continuation beat of a block transfer addresses the next word (word index plus one). A beat that would go past word 2047 of its region gets `bus_err` and closes the transfer. Continuation beats after that get no response.
- R7: Control word 0 bit 0 is the ready flag. It rises once the producer delivers the last word of an accepted event. While ready is set, control word 1 holds the event length in 32-bit words. While ready is clear, control word 1 reads zero.
- R8: `ev_busy` is high while ready is set. Producer words offered during that time are discarded and alter neither the length nor the buffer.
- R9: A host write of 1 to control word 0 bit 0 clears ready and `ev_busy` from the next cycle and empties the buffer for the next event.
- R10: Word k of the event buffer region reads the k-th word of the current event, counting from 0.
- R11: The first accepted event after reset fixes the run's event size. A later event whose word count differs is discarded: ready stays clear and the error counter increments.
- R12: Control word 2 counts `trig_in` pulses. Control word 3 counts error responses and discarded events. A write of any value to word 2 or word 3 clears that counter.
- R13: Writes to the identity region and to regions 6 and 7 are acknowledged and have no effect. Reads of regions 6 and 7 return zero.
- R14: Test memory words below `TEST_WORDS` can be written and read back. A write to the serial command region pulses `ser_cmd_valid` with the data on `ser_cmd_data`, in the same cycle as the acknowledge, and a later read of that region returns the last command. A read of the serial readback region returns `ser_rb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 6 | Geographic slot number of the board |
| bus_stb | input | 1 | Beat strobe, one cycle per beat |
| bus_start | input | 1 | First beat of a bus cycle; address valid |
| bus_blk | input | 1 | Start beat opens a block transfer |
| bus_we | input | 1 | Beat is a write |
| bus_a32 | input | 1 | Cycle uses 32-bit addressing |
| bus_d32 | input | 1 | Cycle uses 32-bit data |
| bus_addr | input | 32 | Byte address of a start beat |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Beat completed |
| bus_err | output | 1 | Beat refused |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| ev_wr | input | 1 | Producer offers an event word |
| ev_data | input | 32 | Producer event word |
| ev_last | input | 1 | Offered word closes the event |
| ev_busy | output | 1 | Buffer holds an unreleased event |
| trig_in | input | 1 | Trigger pulse to count |
| ser_cmd_valid | output | 1 | Serial command strobe |
| ser_cmd_data | output | 32 | Serial command word |
| ser_rb_data | input | 32 | Serial readback word |

## Verification
The hardest situation to reach is the region-edge stop of a block transfer. Nothing at the ports sets the burst's word counter directly, so the stimulus opens a block read on the last word of the test memory region. The first continuation beat must then be refused, and a further continuation beat must get no response at all. The discard of a wrong-sized event is also reached only by sequence: a full event is delivered and released first, so that the run size is fixed, and then a shorter event is pushed.

// File: rtl/geo_rd_pkg.sv
package geo_rd_pkg;

    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int SLOT_W      = 6;
    localparam int WORD_W      = 11;           // 2048 words per 8 KB region
    localparam int REGION_MSB  = 15;
    localparam int REGION_LSB  = 13;

    typedef enum logic [2:0] {
        RG_ID   = 3'd0,
        RG_CSR  = 3'd1,
        RG_TMEM = 3'd2,
        RG_SCMD = 3'd3,
        RG_SRB  = 3'd4,
        RG_EVB  = 3'd5,
        RG_RSV6 = 3'd6,
        RG_RSV7 = 3'd7
    } region_e;

    typedef enum logic {
        CYC_IDLE  = 1'b0,
        CYC_BURST = 1'b1
    } cyc_state_e;

    localparam logic [WORD_W-1:0] CSR_STATUS = WORD_W'(0);
    localparam logic [WORD_W-1:0] CSR_LENGTH = WORD_W'(1);
    localparam logic [WORD_W-1:0] CSR_TRIGS  = WORD_W'(2);
    localparam logic [WORD_W-1:0] CSR_ERRS   = WORD_W'(3);

endpackage

// File: rtl/geo_rd_decode.sv
module geo_rd_decode
    import geo_rd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [SLOT_W-1:0] slot,
    output logic              hit,
    output region_e           region,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        hit    = (addr[ADDR_W-1:22] == '0) &&
                 (addr[21:16] == slot) &&
                 (addr[1:0] == 2'b00);
        region = region_e'(addr[REGION_MSB:REGION_LSB]);
        word   = addr[REGION_LSB-1:2];
    end
endmodule

// File: rtl/geo_rd_evbuf.sv
module geo_rd_evbuf
    import geo_rd_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_wr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_last,
    input  logic              host_clr,
    input  logic [WORD_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic [LEN_W-1:0]  length,
    output logic              size_err
);
    localparam int                IDX_W   = $clog2(DEPTH);
    localparam logic [LEN_W-1:0]  DEPTH_L = LEN_W'(DEPTH);
    localparam logic [WORD_W:0]   DEPTH_R = (WORD_W+1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [LEN_W-1:0]  fill;
    logic [LEN_W-1:0]  run_size;
    logic [LEN_W-1:0]  len_q;
    logic              size_known;
    logic              take;
    logic [LEN_W-1:0]  count;

    assign take  = ev_wr && !ready;
    assign count = fill + LEN_W'(1);

    always_ff @(posedge clk) begin
        if (take && (fill < DEPTH_L)) begin
            mem[fill[IDX_W-1:0]] <= ev_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill       <= '0;
            run_size   <= '0;
            len_q      <= '0;
            size_known <= 1'b0;
            ready      <= 1'b0;
            size_err   <= 1'b0;
        end else begin
            size_err <= 1'b0;
            if (host_clr) begin
                ready <= 1'b0;
                fill  <= '0;
            end
            if (take) begin
                if (ev_last) begin
                    fill <= '0;
                    if (size_known && (count != run_size)) begin
                        size_err <= 1'b1;
                    end else begin
                        ready      <= 1'b1;
                        len_q      <= count;
                        run_size   <= count;
                        size_known <= 1'b1;
                    end
                end else if (fill != '1) begin
                    fill <= count;
                end
            end
        end
    end

    always_comb begin
        length  = ready ? len_q : '0;
        rd_data = ({1'b0, rd_word} < DEPTH_R) ? mem[rd_word[IDX_W-1:0]] : '0;
    end
endmodule

// File: rtl/geo_rd_regs.sv
module geo_rd_regs
    import geo_rd_pkg::*;
#(
    parameter int              TEST_WORDS = 64,
    parameter int              LEN_W      = 12,
    parameter int              CNT_W      = 32,
    parameter logic [DATA_W-1:0] ID_CODE  = 32'h0FED_0A01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              we,
    input  region_e           region,
    input  logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_W-1:0] slot,
    input  logic              trig_in,
    input  logic              err_resp,
    input  logic              err_drop,
    input  logic              ev_ready,
    input  logic [LEN_W-1:0]  ev_len,
    input  logic [DATA_W-1:0] ev_rdata,
    input  logic [DATA_W-1:0] ser_rb_data,
    output logic [DATA_W-1:0] rdata,
    output logic              ser_cmd_valid,
    output logic [DATA_W-1:0] ser_cmd_data
);
    localparam int              TM_IDX = $clog2(TEST_WORDS);
    localparam logic [WORD_W:0] TM_LIM = (WORD_W+1)'(TEST_WORDS);

    logic [DATA_W-1:0] tmem [TEST_WORDS];
    logic [CNT_W-1:0]  trig_cnt;
    logic [CNT_W-1:0]  err_cnt;
    logic              wr_csr;
    logic              tm_in_range;

    assign wr_csr      = acc && we && (region == RG_CSR);
    assign tm_in_range = ({1'b0, word} < TM_LIM);

    always_ff @(posedge clk) begin
        if (acc && we && (region == RG_TMEM) && tm_in_range) begin
            tmem[word[TM_IDX-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_cnt      <= '0;
            err_cnt       <= '0;
            ser_cmd_valid <= 1'b0;
            ser_cmd_data  <= '0;
        end else begin
            if (wr_csr && (word == CSR_TRIGS)) begin
                trig_cnt <= '0;
            end else if (trig_in) begin
                trig_cnt <= trig_cnt + CNT_W'(1);
            end
            if (wr_csr && (word == CSR_ERRS)) begin
                err_cnt <= '0;
            end else begin
                err_cnt <= err_cnt + CNT_W'(err_resp) + CNT_W'(err_drop);
            end
            ser_cmd_valid <= acc && we && (region == RG_SCMD);
            if (acc && we && (region == RG_SCMD)) begin
                ser_cmd_data <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (region)
            RG_ID: begin
                if (word == WORD_W'(0))      rdata = ID_CODE;
                else if (word == WORD_W'(1)) rdata = {{(DATA_W-SLOT_W){1'b0}}, slot};
            end
            RG_CSR: begin
                if (word == CSR_STATUS)      rdata = {{(DATA_W-1){1'b0}}, ev_ready};
                else if (word == CSR_LENGTH) rdata = {{(DATA_W-LEN_W){1'b0}}, ev_len};
                else if (word == CSR_TRIGS)  rdata = DATA_W'(trig_cnt);
                else if (word == CSR_ERRS)   rdata = DATA_W'(err_cnt);
            end
            RG_TMEM: rdata = tm_in_range ? tmem[word[TM_IDX-1:0]] : '0;
            RG_SCMD: rdata = ser_cmd_data;
            RG_SRB:  rdata = ser_rb_data;
            RG_EVB:  rdata = ev_rdata;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/geo_readout_slave.sv
module geo_readout_slave
    import geo_rd_pkg::*;
#(
    parameter int          BUF_WORDS  = 256,
    parameter int          TEST_WORDS = 64,
    parameter int          LEN_W      = 12,
    parameter int          CNT_W      = 32,
    parameter logic [31:0] ID_CODE    = 32'h0FED_0A01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  slot_id,
    input  logic        bus_stb,
    input  logic        bus_start,
    input  logic        bus_blk,
    input  logic        bus_we,
    input  logic        bus_a32,
    input  logic        bus_d32,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic        bus_err,
    output logic [31:0] bus_rdata,
    input  logic        ev_wr,
    input  logic [31:0] ev_data,
    input  logic        ev_last,
    output logic        ev_busy,
    input  logic        trig_in,
    output logic        ser_cmd_valid,
    output logic [31:0] ser_cmd_data,
    input  logic [31:0] ser_rb_data
);
    cyc_state_e        state, state_nxt;
    logic              dec_hit;
    region_e           dec_region;
    logic [WORD_W-1:0] dec_word;
    region_e           burst_region;
    logic [WORD_W-1:0] burst_word;
    region_e           beat_region;
    logic [WORD_W-1:0] beat_word;
    logic              at_edge;
    logic              width_ok;
    logic              accept;
    logic              reject;
    logic              do_acc;
    logic              err_resp;
    logic              host_clr;
    logic              ev_ready;
    logic [LEN_W-1:0]  ev_len;
    logic [DATA_W-1:0] ev_rdata;
    logic              size_err;
    logic [DATA_W-1:0] rd_mux;

    geo_rd_decode u_dec (
        .addr   (bus_addr),
        .slot   (slot_id),
        .hit    (dec_hit),
        .region (dec_region),
        .word   (dec_word)
    );

    // Beat addressing: start beats decode the bus address, continuation
    // beats step the stored word index.
    always_comb begin
        at_edge     = (burst_word == '1);
        beat_region = bus_start ? dec_region : burst_region;
        beat_word   = bus_start ? dec_word : (burst_word + WORD_W'(1));
        width_ok    = bus_a32 && bus_d32;
        accept      = bus_stb && width_ok &&
                      (bus_start ? dec_hit : (state == CYC_BURST));
        reject      = bus_start ? (bus_blk && (dec_region == RG_CSR)) : at_edge;
        do_acc      = accept && !reject;
        err_resp    = accept && reject;
        host_clr    = do_acc && bus_we && (beat_region == RG_CSR) &&
                      (beat_word == CSR_STATUS) && bus_wdata[0];
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            CYC_IDLE: begin
                if (accept && bus_start && bus_blk && !reject) begin
                    state_nxt = CYC_BURST;                  // open_burst
                end
            end
            CYC_BURST: begin
                if (accept) begin
                    if (bus_start) begin
                        state_nxt = (bus_blk && !reject) ? CYC_BURST  // restart_burst
                                                         : CYC_IDLE;  // end_burst
                    end else begin
                        state_nxt = reject ? CYC_IDLE                 // end_burst
                                           : CYC_BURST;               // continue_burst
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CYC_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_region <= RG_ID;
            burst_word   <= '0;
            bus_ack      <= 1'b0;
            bus_err      <= 1'b0;
            bus_rdata    <= '0;
        end else begin
            if (do_acc) begin
                burst_region <= beat_region;
                burst_word   <= beat_word;
            end
            bus_ack   <= do_acc;
            bus_err   <= err_resp;
            bus_rdata <= (do_acc && !bus_we) ? rd_mux : '0;
        end
    end

    geo_rd_evbuf #(
        .DEPTH (BUF_WORDS),
        .LEN_W (LEN_W)
    ) u_evbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_wr    (ev_wr),
        .ev_data  (ev_data),
        .ev_last  (ev_last),
        .host_clr (host_clr),
        .rd_word  (beat_word),
        .rd_data  (ev_rdata),
        .ready    (ev_ready),
        .length   (ev_len),
        .size_err (size_err)
    );

    geo_rd_regs #(
        .TEST_WORDS (TEST_WORDS),
        .LEN_W      (LEN_W),
        .CNT_W      (CNT_W),
        .ID_CODE    (ID_CODE)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc           (do_acc),
        .we            (bus_we),
        .region        (beat_region),
        .word          (beat_word),
        .wdata         (bus_wdata),
        .slot          (slot_id),
        .trig_in       (trig_in),
        .err_resp      (err_resp),
        .err_drop      (size_err),
        .ev_ready      (ev_ready),
        .ev_len        (ev_len),
        .ev_rdata      (ev_rdata),
        .ser_rb_data   (ser_rb_data),
        .rdata         (rd_mux),
        .ser_cmd_valid (ser_cmd_valid),
        .ser_cmd_data  (ser_cmd_data)
    );

    assign ev_busy = ev_ready;
endmodule

// File: rtl/geo_rd_checker.sv
module geo_rd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  slot_id,
    input logic        bus_stb,
    input logic        bus_start,
    input logic        bus_blk,
    input logic        bus_we,
    input logic        bus_a32,
    input logic        bus_d32,
    input logic [31:0] bus_addr,
    input logic        bus_ack,
    input logic        bus_err,
    input logic        ev_busy,
    input logic        ser_cmd_valid
);
    logic geo_ok;
    assign geo_ok = (bus_addr[31:22] == 10'd0) && (bus_addr[21:16] == slot_id) &&
                    (bus_addr[1:0] == 2'b00);

    p_one_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ack && bus_err));

    p_resp_after_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack || bus_err) |-> $past(bus_stb));

    p_width_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !(bus_a32 && bus_d32)) |=> !(bus_ack || bus_err));

    p_geo_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_start && !geo_ok) |=> !(bus_ack || bus_err));

    p_csr_block_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && bus_start && bus_blk && bus_a32 && bus_d32 && geo_ok &&
         bus_addr[15:13] == 3'd1) |=> (bus_err && !bus_ack));

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_busy && !(bus_stb && bus_we)) |=> ev_busy);

    p_cmd_with_ack_r14: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cmd_valid |-> bus_ack);
endmodule

bind geo_readout_slave geo_rd_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_id       (slot_id),
    .bus_stb       (bus_stb),
    .bus_start     (bus_start),
    .bus_blk       (bus_blk),
    .bus_we        (bus_we),
    .bus_a32       (bus_a32),
    .bus_d32       (bus_d32),
    .bus_addr      (bus_addr),
    .bus_ack       (bus_ack),
    .bus_err       (bus_err),
    .ev_busy       (ev_busy),
    .ser_cmd_valid (ser_cmd_valid)
);

// File: tb/geo_readout_slave_test.sv
`timescale 1ns/1ps
module geo_readout_slave_test;
    localparam logic [31:0] IDC = 32'h0FED_0A01;
    localparam int RESP_NONE = 0;
    localparam int RESP_ACK  = 1;
    localparam int RESP_ERR  = 2;

    typedef struct {
        int          resp;
        logic [31:0] data;
        bit          chk_data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  slot_id = 6'd17;
    logic        bus_stb = 1'b0, bus_start = 1'b0, bus_blk = 1'b0, bus_we = 1'b0;
    logic        bus_a32 = 1'b1, bus_d32 = 1'b1;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        ev_wr = 1'b0, ev_last = 1'b0;
    logic [31:0] ev_data = '0;
    logic        ev_busy;
    logic        trig_in = 1'b0;
    logic        ser_cmd_valid;
    logic [31:0] ser_cmd_data;
    logic [31:0] ser_rb_data = 32'h5A5A_1234;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    geo_readout_slave uut (
        .clk(clk), .rst_n(rst_n), .slot_id(slot_id),
        .bus_stb(bus_stb), .bus_start(bus_start), .bus_blk(bus_blk), .bus_we(bus_we),
        .bus_a32(bus_a32), .bus_d32(bus_d32), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .ev_wr(ev_wr), .ev_data(ev_data), .ev_last(ev_last), .ev_busy(ev_busy),
        .trig_in(trig_in), .ser_cmd_valid(ser_cmd_valid), .ser_cmd_data(ser_cmd_data),
        .ser_rb_data(ser_rb_data)
    );

    function automatic logic [31:0] adr(input logic [5:0] s, input int rg, input int wd);
        return {10'd0, s, 16'd0} | (32'(rg) << 13) | (32'(wd) << 2);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: queue expectation, then issue a one-cycle beat.
    task automatic beat(input bit st, input bit blk, input bit we, input logic [31:0] a,
                        input logic [31:0] wd, input int resp, input logic [31:0] rd,
                        input string tag);
        exp_t e;
        e.resp = resp; e.data = rd; e.chk_data = (!we && resp == RESP_ACK); e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        bus_stb = 1'b1; bus_start = st; bus_blk = blk; bus_we = we;
        bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_stb = 1'b0; bus_start = 1'b0; bus_blk = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd1(input logic [31:0] a, input logic [31:0] exp, input string tag);
        beat(1'b1, 1'b0, 1'b0, a, 32'd0, RESP_ACK, exp, tag);
    endtask

    task automatic wr1(input logic [31:0] a, input logic [31:0] d, input string tag);
        beat(1'b1, 1'b0, 1'b1, a, d, RESP_ACK, 32'd0, tag);
    endtask

    task automatic produce(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ev_wr = 1'b1; ev_data = base + 32'(i); ev_last = (i == n - 1);
        end
        @(negedge clk);
        ev_wr = 1'b0; ev_last = 1'b0;
    endtask

    // Monitor: after every edge with a strobe, compare the response.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_stb) begin
                @(negedge clk);
                if (expq.size() == 0) begin
                    check(1'b0, "R3 unexpected beat", 32'd0, 32'd0);
                end else begin
                    exp_t e;
                    int   got;
                    e = expq.pop_front();
                    got = bus_ack ? (bus_err ? 3 : RESP_ACK) : (bus_err ? RESP_ERR : RESP_NONE);
                    check(got == e.resp, {e.tag, " resp"}, 32'(got), 32'(e.resp));
                    if (e.chk_data)
                        check(bus_rdata == e.data, {e.tag, " data"}, bus_rdata, e.data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ev_busy == 1'b0, "reset ev_busy", 32'(ev_busy), 32'd0);
        check(bus_ack == 1'b0 && bus_err == 1'b0, "reset resp", {30'd0, bus_ack, bus_err}, 32'd0);

        // R4 identity region, R2 slot decode
        rd1(adr(6'd17, 0, 0), IDC, "R4 id word0");
        rd1(adr(6'd17, 0, 1), 32'd17, "R4 R2 id slot");
        beat(1'b1, 1'b0, 1'b0, adr(6'd18, 0, 0), 0, RESP_NONE, 0, "R2 other slot");
        beat(1'b1, 1'b0, 1'b0, adr(6'd17, 0, 0) | 32'h0040_0000, 0, RESP_NONE, 0, "R2 upper bits");
        // R1 width filter
        bus_a32 = 1'b0;
        beat(1'b1, 1'b0, 1'b0, adr(6'd17, 0, 0), 0, RESP_NONE, 0, "R1 a16");
        bus_a32 = 1'b1; bus_d32 = 1'b0;
        beat(1'b1, 1'b0, 1'b0, adr(6'd17, 0, 0), 0, RESP_NONE, 0, "R1 d16");
        bus_d32 = 1'b1;

        // R7 idle status
        rd1(adr(6'd17, 1, 0), 32'd0, "R7 status idle");
        rd1(adr(6'd17, 1, 1), 32'd0, "R7 length idle");

        // R7 R8 event load
        produce(5, 32'hA000);
        check(ev_busy == 1'b1, "R8 busy after event", 32'(ev_busy), 32'd1);
        rd1(adr(6'd17, 1, 0), 32'd1, "R7 status ready");
        rd1(adr(6'd17, 1, 1), 32'd5, "R7 length");
        produce(1, 32'hDEAD);
        rd1(adr(6'd17, 1, 1), 32'd5, "R8 length kept");
        rd1(adr(6'd17, 5, 0), 32'hA000, "R8 R10 word0 kept");

        // R6 R10 block read of the event
        beat(1'b1, 1'b1, 1'b0, adr(6'd17, 5, 0), 0, RESP_ACK, 32'hA000, "R6 R10 blk b0");
        for (int k = 1; k < 5; k++)
            beat(1'b0, 1'b0, 1'b0, 32'd0, 0, RESP_ACK, 32'hA000 + 32'(k), "R6 R10 blk bk");

        // R5 block to control region refused
        beat(1'b1, 1'b1, 1'b1, adr(6'd17, 1, 0), 32'd1, RESP_ERR, 0, "R5 csr block");
        rd1(adr(6'd17, 1, 0), 32'd1, "R5 status unchanged");
        rd1(adr(6'd17, 1, 3), 32'd1, "R12 err count 1");

        // R9 release
        wr1(adr(6'd17, 1, 0), 32'd1, "R9 release");
        check(ev_busy == 1'b0, "R9 busy drops", 32'(ev_busy), 32'd0);
        rd1(adr(6'd17, 1, 0), 32'd0, "R9 status cleared");
        rd1(adr(6'd17, 1, 1), 32'd0, "R9 R7 length zero");

        // R11 wrong size dropped, right size accepted
        produce(3, 32'hC000);
        check(ev_busy == 1'b0, "R11 short event dropped", 32'(ev_busy), 32'd0);
        rd1(adr(6'd17, 1, 3), 32'd2, "R11 err count 2");
        produce(5, 32'hB000);
        rd1(adr(6'd17, 1, 1), 32'd5, "R11 length");
        rd1(adr(6'd17, 5, 4), 32'hB004, "R11 R10 word4");

        // R6 region edge
        beat(1'b1, 1'b1, 1'b0, adr(6'd17, 2, 2047), 0, RESP_ACK, 32'd0, "R6 edge start");
        beat(1'b0, 1'b0, 1'b0, 32'd0, 0, RESP_ERR, 0, "R6 edge cross");
        beat(1'b0, 1'b0, 1'b0, 32'd0, 0, RESP_NONE, 0, "R6 after close");
        rd1(adr(6'd17, 1, 3), 32'd3, "R12 err count 3");

        // R12 triggers and clears
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); trig_in = 1'b1;
            @(negedge clk); trig_in = 1'b0;
        end
        rd1(adr(6'd17, 1, 2), 32'd3, "R12 trig count");
        wr1(adr(6'd17, 1, 2), 32'd0, "R12 trig clear");
        rd1(adr(6'd17, 1, 2), 32'd0, "R12 trig zero");
        wr1(adr(6'd17, 1, 3), 32'd0, "R12 err clear");
        rd1(adr(6'd17, 1, 3), 32'd0, "R12 err zero");

        // R13 ignored writes
        wr1(adr(6'd17, 0, 0), 32'h1234_5678, "R13 id write");
        rd1(adr(6'd17, 0, 0), IDC, "R13 id unchanged");
        wr1(adr(6'd17, 6, 3), 32'hFFFF_FFFF, "R13 rsv write");
        rd1(adr(6'd17, 6, 3), 32'd0, "R13 rsv6 zero");
        rd1(adr(6'd17, 7, 0), 32'd0, "R13 rsv7 zero");

        // R14 test memory, serial command, readback
        wr1(adr(6'd17, 2, 7), 32'hCAFE_0007, "R14 tmem write");
        wr1(adr(6'd17, 2, 8), 32'hCAFE_0008, "R14 tmem write");
        rd1(adr(6'd17, 2, 7), 32'hCAFE_0007, "R14 tmem read7");
        rd1(adr(6'd17, 2, 8), 32'hCAFE_0008, "R14 tmem read8");
        wr1(adr(6'd17, 3, 0), 32'h0BAD_F00D, "R14 cmd write");
        check(ser_cmd_valid == 1'b1, "R14 cmd strobe", 32'(ser_cmd_valid), 32'd1);
        check(ser_cmd_data == 32'h0BAD_F00D, "R14 cmd data", ser_cmd_data, 32'h0BAD_F00D);
        @(negedge clk);
        check(ser_cmd_valid == 1'b0, "R14 cmd one cycle", 32'(ser_cmd_valid), 32'd0);
        rd1(adr(6'd17, 3, 0), 32'h0BAD_F00D, "R14 cmd readback");
        rd1(adr(6'd17, 4, 0), 32'h5A5A_1234, "R14 serial readback");

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R3 all beats answered", 32'(expq.size()), 32'd0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule